// File: doc/BRIEF.md
# Cascadable Interrupt Status Controller

This block gathers interrupt events into a status register, masks them with an enable register and raises one registered interrupt request. It has two kinds of status field. A local field watches a hardware event line. The line is synchronized, and a rising edge sets the field. The field then stays set until software writes a 1 to it. A child field is a live copy of the request output of another controller one level down the hierarchy. It is never latched, and software clears the event at its origin.

Because the request output of one controller can drive a child field of another, identical controllers can be chained into a tree. The root's request drives a host interrupt line. The index of that line is a parameter, reported on a constant output, and it is 0 unless it is set. Software reaches both registers over a minimal word bus. A write takes effect on the clock edge where it is presented. Read data is registered and appears one cycle after the read strobe.

Top module: `irqc_node`

## Requirements
- R1: A local field `k` (bit `k` of status, for `k < N_LOCAL`) becomes 1 on the edge after its synchronized event line goes from 0 to 1. The event line is sampled by two flip-flops and then compared with a one-cycle delayed copy. A line that stays high sets the field only once.
- R2: A bus write to offset 0x0 clears every local field whose write-data bit is 1 and leaves fields whose bit is 0 unchanged.
- R3: The enable register is at offset 0x4 and has bit `i` matching status bit `i`. A write stores `wdata[N_LOCAL+N_CHILD-1:0]` and drops the higher data bits. A read returns the stored bits, with 0 above them.
- R4: Child field `j` (status bit `N_LOCAL+j`) reads as the present level of `child_irq[j]`, with no latching.
- R5: A write of 1 to a child field has no effect on it.
- R6: `irq_out` is a flip-flop output. After each edge it equals the OR over all bits of (status AND enable) as they stood before that edge.
- R7: When a rising edge and a clearing write meet on the same local field in the same cycle, the field ends up set.
- R8: While `rst` is high, and after it, status local fields, enable, `irq_out` and `bus_rdata` are 0.
- R9: `irq_line` constantly reports the parameter `LINE_ID`, which defaults to 0.
- R10: A read registers on the next edge. Offset 0x0 returns status, with local fields in the low bits and child fields above them. Offset 0x4 returns enable. Any other offset returns 0. Without a read, `bus_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| src_evt | input | N_LOCAL | Local event lines, asynchronous |
| child_irq | input | N_CHILD | Request outputs of child controllers |
| irq_out | output | 1 | Registered interrupt request |
| irq_line | output | 8 | Interrupt line index (LINE_ID) |

## Verification
On every cycle, the assertions check these points:
- A local field rises only where the edge detector fired, and a set local field stays set unless a clearing write hits it.
- A clearing write with no competing edge leaves the field at 0.
- An enable write stores the masked data.
- An all-zero enable keeps the request low.

Some behaviours appear only in the bench's scenarios, which compare every cycle against a behavioural model:
- the exact latency through the synchronizer;
- a held-high line producing a single capture;
- the edge winning against a same-cycle clear;
- child fields following their input while ignoring writes;
- the read-data contents.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned STAT_OFS = 0;
  localparam int unsigned EN_OFS   = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [31:0] ofs);
    if (ofs == 32'(STAT_OFS))
      return SEL_STAT;
    else if (ofs == 32'(EN_OFS))
      return SEL_EN;
    else
      return SEL_NONE;
  endfunction

endpackage

// File: rtl/irqc_edge.sv
// Per-line synchronizer followed by a rising-edge detector.
module irqc_edge #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_in,
  output logic [N_LINES-1:0] rise_o
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic              dly_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        dly_q  <= 1'b0;
      end else begin
        if (STAGES > 1)
          sync_q <= {sync_q[STAGES-2:0], lines_in[g]};
        else
          sync_q <= lines_in[g];
        dly_q <= sync_q[LAST];
      end
    end

    assign rise_o[g] = sync_q[LAST] & ~dly_q;
  end

endmodule

// File: rtl/irqc_status.sv
// Status fields: sticky local fields and live child mirrors.
module irqc_status #(
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_CHILD = 2,
  localparam int unsigned NS     = N_LOCAL + N_CHILD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LOCAL-1:0] rise_i,
  input  logic [N_CHILD-1:0] child_i,
  input  logic               clr_we_i,
  input  logic [N_LOCAL-1:0] clr_mask_i,
  output logic [NS-1:0]      stat_o
);

  logic [N_LOCAL-1:0] loc_q;
  logic [N_LOCAL-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // A new edge overrides a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst)
      loc_q <= '0;
    else
      loc_q <= (loc_q & ~clr_eff) | rise_i;
  end

  if (N_CHILD > 0) begin : g_child
    assign stat_o = {child_i, loc_q};
  end else begin : g_nochild
    assign stat_o = loc_q;
  end

endmodule

// File: rtl/irqc_regs.sv
// Bus decode, enable register and registered read path.
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_CHILD = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned NS     = N_LOCAL + N_CHILD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NS-1:0]      stat_i,
  output logic [NS-1:0]      en_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               clr_we_o,
  output logic [N_LOCAL-1:0] clr_mask_o
);

  reg_sel_e          sel;
  logic [NS-1:0]     en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel        = decode_sel(32'(addr_i));
  assign clr_we_o   = wr_i && (sel == SEL_STAT);
  assign clr_mask_o = wdata_i[N_LOCAL-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (wr_i && sel == SEL_EN)
      en_q <= wdata_i[NS-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: rd_mux[NS-1:0] = stat_i;
      SEL_EN:   rd_mux[NS-1:0] = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (rd_i)
      rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/irqc_node.sv
module irqc_node #(
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_CHILD = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned STAGES  = 2,
  parameter int unsigned LINE_ID = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N_LOCAL-1:0] src_evt,
  input  logic [N_CHILD-1:0] child_irq,
  output logic               irq_out,
  output logic [7:0]         irq_line
);

  localparam int unsigned NS = N_LOCAL + N_CHILD;

  logic [N_LOCAL-1:0] rise_w;
  logic [NS-1:0]      stat_w;
  logic [NS-1:0]      en_w;
  logic               clr_we_w;
  logic [N_LOCAL-1:0] clr_mask_w;
  logic               irq_q;

  irqc_edge #(.N_LINES(N_LOCAL), .STAGES(STAGES)) edge_i (
    .clk(clk), .rst(rst), .lines_in(src_evt), .rise_o(rise_w)
  );

  irqc_status #(.N_LOCAL(N_LOCAL), .N_CHILD(N_CHILD)) stat_i (
    .clk(clk), .rst(rst), .rise_i(rise_w), .child_i(child_irq),
    .clr_we_i(clr_we_w), .clr_mask_i(clr_mask_w), .stat_o(stat_w)
  );

  irqc_regs #(.N_LOCAL(N_LOCAL), .N_CHILD(N_CHILD), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .stat_i(stat_w), .en_o(en_w), .rdata_o(bus_rdata),
    .clr_we_o(clr_we_w), .clr_mask_o(clr_mask_w)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else
      irq_q <= |(stat_w & en_w);
  end

  assign irq_out  = irq_q;
  assign irq_line = 8'(LINE_ID);

endmodule

// File: rtl/irqc_node_chk.sv
module irqc_node_chk #(
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_CHILD = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned NS     = N_LOCAL + N_CHILD
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq_out,
  input logic [NS-1:0]      stat,
  input logic [NS-1:0]      en,
  input logic [N_LOCAL-1:0] rise
);

  logic wr_stat, wr_en;
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(0));
  assign wr_en   = bus_wr && (bus_addr == ADDR_W'(4));

  for (genvar i = 0; i < N_LOCAL; i++) begin : g_bit
    // R1
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[i]) |-> $past(rise[i]));
    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(stat[i]) && !($past(wr_stat) && $past(bus_wdata[i]))) |-> stat[i]);
    // R2
    clear_done_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_stat) && $past(bus_wdata[i]) && !$past(rise[i])) |-> !stat[i]);
  end

  // R3
  en_store_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (en == $past(bus_wdata[NS-1:0])));

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(en) == '0) |-> !irq_out);

endmodule

bind irqc_node irqc_node_chk #(
  .N_LOCAL(N_LOCAL), .N_CHILD(N_CHILD), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_out(irq_out), .stat(stat_w), .en(en_w),
  .rise(rise_w)
);

// File: tb/irqc_node_test.sv
`timescale 1ns/1ps
module irqc_node_test;

  localparam int NL = 4;
  localparam int NC = 2;
  localparam int NS = NL + NC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] src_evt = '0;
  logic [NC-1:0] child_irq = '0;
  logic        irq_out;
  logic [7:0]  irq_line;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqc_node uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .child_irq(child_irq), .irq_out(irq_out), .irq_line(irq_line)
  );

  // Behavioural reference model
  logic [NL-1:0] m_hist [$];
  logic [NL-1:0] m_prev;
  logic [NL-1:0] m_loc;
  logic [NS-1:0] m_en;
  logic          m_irq;
  logic [31:0]   m_rdata;

  initial begin
    m_hist = {'0, '0};
    m_prev = '0; m_loc = '0; m_en = '0; m_irq = 0; m_rdata = '0;
  end

  always @(posedge clk) begin
    logic [NL-1:0] synced, edges, clr;
    logic [NS-1:0] full;
    synced = m_hist[0];
    full   = {child_irq, m_loc};
    if (rst) begin
      m_hist = {'0, '0}; m_prev = '0; m_loc = '0; m_en = '0; m_irq = 0; m_rdata = '0;
    end else begin
      edges = synced & ~m_prev;
      clr = (bus_wr && bus_addr == 4'd0) ? bus_wdata[NL-1:0] : '0;
      m_irq = |(full & m_en);
      if (bus_rd)
        m_rdata = (bus_addr == 4'd0) ? 32'(full) : (bus_addr == 4'd4) ? 32'(m_en) : 32'd0;
      m_loc = (m_loc & ~clr) | edges;
      if (bus_wr && bus_addr == 4'd4) m_en = bus_wdata[NS-1:0];
      m_prev = synced;
      void'(m_hist.pop_front());
      m_hist.push_back(src_evt);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done && cyc > 2) begin
      check("R6 irq model", 32'(irq_out), 32'(m_irq));
      check("R10 rdata model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    check("R8 irq in reset", 32'(irq_out), 0);
    @(negedge clk); rst = 0;
    rd(4'd0, v); check("R8 status after reset", v, 0);
    rd(4'd4, v); check("R8 enable after reset", v, 0);
    check("R9 line index", 32'(irq_line), 0);

    // R1: capture on edge, held level does not re-set
    @(negedge clk); src_evt[0] = 1;
    idle(5);
    rd(4'd0, v); check("R1 edge capture", v, 32'h1);
    check("R6 masked off", 32'(irq_out), 0);
    wr(4'd0, 32'h1);
    idle(4);
    rd(4'd0, v); check("R1 held level no recapture", v, 0);
    @(negedge clk); src_evt[0] = 0;
    idle(4);

    // R2/R6: enable, clear with 0 then 1
    @(negedge clk); src_evt[2] = 1; idle(1); src_evt[2] = 0;
    idle(5);
    wr(4'd4, 32'h4);
    idle(1);
    check("R6 irq asserted", 32'(irq_out), 1);
    wr(4'd0, 32'h0);
    rd(4'd0, v); check("R2 zero write keeps bit", v, 32'h4);
    wr(4'd0, 32'h4);
    idle(1);
    rd(4'd0, v); check("R2 one write clears", v, 0);
    check("R6 irq drops", 32'(irq_out), 0);

    // R3: upper data bits dropped
    wr(4'd4, 32'hFFFF_FFFF);
    rd(4'd4, v); check("R3 enable width", v, 32'h3F);
    wr(4'd4, 32'h0);
    rd(4'd8, v); check("R10 unmapped offset", v, 0);

    // R4/R5: child fields
    @(negedge clk); child_irq = 2'b10;
    rd(4'd0, v); check("R4 child mirror high", v, 32'h20);
    wr(4'd0, 32'h30);
    rd(4'd0, v); check("R5 child ignores write", v, 32'h20);
    wr(4'd4, 32'h20);
    idle(1);
    check("R4 child drives irq", 32'(irq_out), 1);
    @(negedge clk); child_irq = 2'b00;
    rd(4'd0, v); check("R4 child mirror low", v, 0);
    idle(1);
    check("R4 irq follows child", 32'(irq_out), 0);

    // R7: edge and clear collide on bit 1
    @(negedge clk); src_evt[1] = 1; idle(1); src_evt[1] = 0;
    idle(5);
    rd(4'd0, v); check("R7 precondition", v, 32'h2);
    @(negedge clk); src_evt[1] = 1;       // N0
    @(negedge clk); @(negedge clk);       // after P2 the edge is live
    bus_wr = 1; bus_addr = 4'd0; bus_wdata = 32'h2;
    @(negedge clk); bus_wr = 0; src_evt[1] = 0;
    rd(4'd0, v); check("R7 edge wins", v, 32'h2);

    // multi-bit pattern
    @(negedge clk); src_evt = 4'b1001; idle(1); src_evt = 4'b0000;
    idle(5);
    wr(4'd4, 32'h8);
    rd(4'd0, v); check("R1 multi capture", v, 32'hB);
    idle(1);
    check("R6 irq bit3", 32'(irq_out), 1);
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule